// File: doc/BRIEF.md
# Descriptor Memory Access Controller

This block sits in front of the single-port synchronous RAM that holds the channel transfer control descriptors of a DMA controller. It offers two logical ports on the same storage. One belongs to the DMA engine, which fetches and writes back descriptors while it moves data. The other belongs to the peripheral register bus, through which software programs the descriptors. In every cycle at most one of the two owns the RAM. The controller routes that port's address, write data and byte enables to the array.

The engine has strict priority. When both ports request in the same cycle, the engine's access goes through. The peripheral access is held off with a wait indication rather than rejected. The peripheral master keeps its address and data stable while the wait is high, and the access completes in the first cycle the engine leaves the RAM free. Read data returns one clock after the grant. A valid strobe marks it on the port that issued the read, so each requester sees only its own responses. Byte enables let software or the engine rewrite single fields of a descriptor word without a read-modify-write.

Top module: `dma_desc_mem_ctl`

## Requirements
- R1: A read from the engine port is served in the cycle it is requested. `eng_rvalid` is high in the following cycle, and `eng_rdata` carries the addressed word.
- R2: When `eng_req` and `pb_req` are both high, the engine access is performed. `pb_wait` is high in that same cycle, and the peripheral access neither writes the RAM nor produces read data.
- R3: When `pb_req` is high and `eng_req` is low, the peripheral access is performed in that cycle and `pb_wait` is low.
- R4: Read data is tagged to its port. A granted read raises only that port's valid one cycle later. A write raises neither valid. A port's read data bus is zero whenever its valid is low.
- R5: On a write, byte lane k (bits 8k+7..8k) is updated only when bit k of the byte enable is 1. A write with all enables 0 leaves the word unchanged.
- R6: A read returns the word as left by all writes granted in earlier cycles.
- R7: After synchronous active-high reset, `eng_rvalid`, `pb_rvalid` and both read data buses are 0.
- R8: A peripheral access stalled for one or more cycles, with its inputs held, is performed with those inputs in the first cycle that `eng_req` is low.
- R9: `pb_wait` is low in any cycle where `pb_req` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| eng_req | input | 1 | Engine access request |
| eng_we | input | 1 | Engine write (1) or read (0) |
| eng_addr | input | ADDR_W | Engine word address |
| eng_wdata | input | DATA_W | Engine write data |
| eng_be | input | DATA_W/8 | Engine byte enables |
| eng_rvalid | output | 1 | Engine read data valid |
| eng_rdata | output | DATA_W | Engine read data |
| pb_req | input | 1 | Peripheral bus access request |
| pb_we | input | 1 | Peripheral write (1) or read (0) |
| pb_addr | input | ADDR_W | Peripheral word address |
| pb_wdata | input | DATA_W | Peripheral write data |
| pb_be | input | DATA_W/8 | Peripheral byte enables |
| pb_wait | output | 1 | Peripheral access stalled this cycle |
| pb_rvalid | output | 1 | Peripheral read data valid |
| pb_rdata | output | DATA_W | Peripheral read data |

## Verification
The bench builds the block with ADDR_W=3 and the default DATA_W=32. The array then has only eight words, so random traffic keeps landing on addresses that were just written by either port. Reads straight after writes and engine and peripheral traffic on the same word therefore happen often. With four byte lanes, every mix of partial enables, including none at all, can be tried against the reference array. Long engine bursts with a held peripheral request exercise stalls of several cycles.

// File: rtl/dma_desc_pkg.sv
package dma_desc_pkg;

    localparam int unsigned DEF_ADDR_W = 6;
    localparam int unsigned DEF_DATA_W = 32;

    typedef enum logic [1:0] {
        OWN_NONE = 2'd0,
        OWN_ENG  = 2'd1,
        OWN_PB   = 2'd2
    } owner_e;

    typedef struct packed {
        logic   valid;
        owner_e owner;
    } rsp_tag_t;

    function automatic owner_e pick_owner(input logic eng_req, input logic pb_req);
        if (eng_req)
            return OWN_ENG;
        else if (pb_req)
            return OWN_PB;
        return OWN_NONE;
    endfunction

endpackage

// File: rtl/dma_desc_arb.sv
module dma_desc_arb
    import dma_desc_pkg::*;
(
    input  logic   eng_req,
    input  logic   pb_req,
    output owner_e owner,
    output logic   pb_wait
);
    always_comb begin
        owner   = pick_owner(eng_req, pb_req);
        pb_wait = pb_req && (owner != OWN_PB);
    end
endmodule

// File: rtl/dma_desc_ram.sv
module dma_desc_ram #(
    parameter int unsigned ADDR_W = 6,
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              en,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W/8-1:0] be,
    output logic [DATA_W-1:0] q
);
    localparam int unsigned DEPTH = 1 << ADDR_W;
    localparam int unsigned LANES = DATA_W / 8;

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (en) begin
            if (we) begin
                for (int k = 0; k < LANES; k++) begin
                    if (be[k])
                        mem[addr][k*8 +: 8] <= wdata[k*8 +: 8];
                end
            end else begin
                q <= mem[addr];
            end
        end
    end
endmodule

// File: rtl/dma_desc_rsp.sv
module dma_desc_rsp
    import dma_desc_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  owner_e            owner,
    input  logic              rd_now,
    input  logic [DATA_W-1:0] ram_q,
    output logic              eng_rvalid,
    output logic [DATA_W-1:0] eng_rdata,
    output logic              pb_rvalid,
    output logic [DATA_W-1:0] pb_rdata
);
    rsp_tag_t tag_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            tag_q <= '{valid: 1'b0, owner: OWN_NONE};
        end else begin
            tag_q.valid <= rd_now && (owner != OWN_NONE);
            tag_q.owner <= owner;
        end
    end

    localparam int unsigned NPORT = 2;
    logic [NPORT-1:0]  vld;
    logic [DATA_W-1:0] dat [NPORT];

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        localparam owner_e MINE = (p == 0) ? OWN_ENG : OWN_PB;
        assign vld[p] = tag_q.valid && (tag_q.owner == MINE);
        assign dat[p] = vld[p] ? ram_q : '0;
    end

    assign eng_rvalid = vld[0];
    assign eng_rdata  = dat[0];
    assign pb_rvalid  = vld[1];
    assign pb_rdata   = dat[1];
endmodule

// File: rtl/dma_desc_mem_ctl.sv
module dma_desc_mem_ctl
    import dma_desc_pkg::*;
#(
    parameter int unsigned ADDR_W = DEF_ADDR_W,
    parameter int unsigned DATA_W = DEF_DATA_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                eng_req,
    input  logic                eng_we,
    input  logic [ADDR_W-1:0]   eng_addr,
    input  logic [DATA_W-1:0]   eng_wdata,
    input  logic [DATA_W/8-1:0] eng_be,
    output logic                eng_rvalid,
    output logic [DATA_W-1:0]   eng_rdata,
    input  logic                pb_req,
    input  logic                pb_we,
    input  logic [ADDR_W-1:0]   pb_addr,
    input  logic [DATA_W-1:0]   pb_wdata,
    input  logic [DATA_W/8-1:0] pb_be,
    output logic                pb_wait,
    output logic                pb_rvalid,
    output logic [DATA_W-1:0]   pb_rdata
);
    localparam int unsigned BE_W = DATA_W / 8;

    owner_e             owner;
    logic               ram_en;
    logic               ram_we;
    logic [ADDR_W-1:0]  ram_addr;
    logic [DATA_W-1:0]  ram_wdata;
    logic [BE_W-1:0]    ram_be;
    logic [DATA_W-1:0]  ram_q;

    dma_desc_arb u_arb (
        .eng_req (eng_req),
        .pb_req  (pb_req),
        .owner   (owner),
        .pb_wait (pb_wait)
    );

    always_comb begin
        ram_en    = (owner != OWN_NONE);
        ram_we    = 1'b0;
        ram_addr  = '0;
        ram_wdata = '0;
        ram_be    = '0;
        unique case (owner)
            OWN_ENG: begin
                ram_we    = eng_we;
                ram_addr  = eng_addr;
                ram_wdata = eng_wdata;
                ram_be    = eng_be;
            end
            OWN_PB: begin
                ram_we    = pb_we;
                ram_addr  = pb_addr;
                ram_wdata = pb_wdata;
                ram_be    = pb_be;
            end
            default: ;
        endcase
    end

    dma_desc_ram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ram (
        .clk   (clk),
        .en    (ram_en),
        .we    (ram_we),
        .addr  (ram_addr),
        .wdata (ram_wdata),
        .be    (ram_be),
        .q     (ram_q)
    );

    dma_desc_rsp #(.DATA_W(DATA_W)) u_rsp (
        .clk        (clk),
        .rst        (rst),
        .owner      (owner),
        .rd_now     (!ram_we),
        .ram_q      (ram_q),
        .eng_rvalid (eng_rvalid),
        .eng_rdata  (eng_rdata),
        .pb_rvalid  (pb_rvalid),
        .pb_rdata   (pb_rdata)
    );
endmodule

// File: rtl/dma_desc_mem_ctl_chk.sv
module dma_desc_mem_ctl_chk (
    input logic clk,
    input logic rst,
    input logic eng_req,
    input logic eng_we,
    input logic pb_req,
    input logic pb_we,
    input logic pb_wait,
    input logic eng_rvalid,
    input logic pb_rvalid
);
    p_eng_read_r1: assert property (@(posedge clk) disable iff (rst)
        (eng_req && !eng_we) |=> (eng_rvalid && !pb_rvalid));

    p_stall_r2: assert property (@(posedge clk) disable iff (rst)
        (eng_req && pb_req) |-> pb_wait);

    p_stall_nodata_r2: assert property (@(posedge clk) disable iff (rst)
        (eng_req && pb_req) |=> !pb_rvalid);

    p_pb_alone_r3: assert property (@(posedge clk) disable iff (rst)
        (pb_req && !eng_req) |-> !pb_wait);

    p_pb_read_r4: assert property (@(posedge clk) disable iff (rst)
        (pb_req && !pb_we && !eng_req) |=> (pb_rvalid && !eng_rvalid));

    p_tag_onehot_r4: assert property (@(posedge clk) disable iff (rst)
        $onehot0({eng_rvalid, pb_rvalid}));

    p_write_silent_r4: assert property (@(posedge clk) disable iff (rst)
        (eng_req && eng_we) |=> (!eng_rvalid && !pb_rvalid));

    p_reset_clear_r7: assert property (@(posedge clk)
        rst |=> (!eng_rvalid && !pb_rvalid));

    p_idle_nowait_r9: assert property (@(posedge clk) disable iff (rst)
        !pb_req |-> !pb_wait);
endmodule

bind dma_desc_mem_ctl dma_desc_mem_ctl_chk u_chk (.*);

// File: tb/dma_desc_mem_ctl_tb.sv
module dma_desc_mem_ctl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 3;
    localparam int DW = 32;
    localparam int BW = DW / 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic eng_req = 0, eng_we = 0;
    logic [AW-1:0] eng_addr = '0;
    logic [DW-1:0] eng_wdata = '0;
    logic [BW-1:0] eng_be = '0;
    logic eng_rvalid;
    logic [DW-1:0] eng_rdata;
    logic pb_req = 0, pb_we = 0;
    logic [AW-1:0] pb_addr = '0;
    logic [DW-1:0] pb_wdata = '0;
    logic [BW-1:0] pb_be = '0;
    logic pb_wait, pb_rvalid;
    logic [DW-1:0] pb_rdata;

    always #(CLK_PERIOD/2) clk = ~clk;

    dma_desc_mem_ctl #(.ADDR_W(AW), .DATA_W(DW)) u_dut (.*);

    int total = 0;
    int bad = 0;
    bit done = 0;

    logic [DW-1:0] model [1 << AW];
    logic          x_erv = 0, x_prv = 0;
    logic [DW-1:0] x_erd = '0, x_prd = '0;

    task automatic chk(string tag, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic apply_model(logic ew, logic [AW-1:0] ea, logic [DW-1:0] ed, logic [BW-1:0] eb);
        if (!ew)
            x_erd = model[ea];
        else
            for (int k = 0; k < BW; k++)
                if (eb[k]) model[ea][k*8 +: 8] = ed[k*8 +: 8];
    endtask

    task automatic step(logic er, logic ew, logic [AW-1:0] ea, logic [DW-1:0] ed, logic [BW-1:0] eb,
                        logic pr, logic pw, logic [AW-1:0] pa, logic [DW-1:0] pd, logic [BW-1:0] pbe,
                        string dtag);
        @(negedge clk);
        chk("R1", "eng_rvalid", {31'd0, eng_rvalid}, {31'd0, x_erv});
        chk(dtag, "eng_rdata", eng_rdata, x_erv ? x_erd : '0);
        chk("R4", "pb_rvalid", {31'd0, pb_rvalid}, {31'd0, x_prv});
        chk(dtag, "pb_rdata", pb_rdata, x_prv ? x_prd : '0);
        eng_req = er; eng_we = ew; eng_addr = ea; eng_wdata = ed; eng_be = eb;
        pb_req = pr; pb_we = pw; pb_addr = pa; pb_wdata = pd; pb_be = pbe;
        #1;
        chk(pr ? (er ? "R2" : "R3") : "R9", "pb_wait", {31'd0, pb_wait}, {31'd0, pr && er});
        x_erv = 0; x_prv = 0;
        if (er) begin
            x_erv = !ew;
            apply_model(ew, ea, ed, eb);
        end else if (pr) begin
            x_prv = !pw;
            if (!pw) x_prd = model[pa];
            else for (int k = 0; k < BW; k++)
                if (pbe[k]) model[pa][k*8 +: 8] = pd[k*8 +: 8];
        end
    endtask

    task automatic idle(string dtag);
        step(0, 0, '0, '0, '0, 0, 0, '0, '0, '0, dtag);
    endtask

    initial begin
        for (int i = 0; i < (1 << AW); i++) model[i] = '0;
        repeat (3) @(negedge clk);
        chk("R7", "eng_rvalid", {31'd0, eng_rvalid}, '0);
        chk("R7", "pb_rvalid", {31'd0, pb_rvalid}, '0);
        chk("R7", "eng_rdata", eng_rdata, '0);
        chk("R7", "pb_rdata", pb_rdata, '0);
        rst = 0;
        // initialise every word through the engine port
        for (int i = 0; i < (1 << AW); i++)
            step(1, 1, i[AW-1:0], 32'h1000_0000 + i, 4'hF, 0, 0, '0, '0, '0, "R6");
        // engine read, then peripheral alone (R1, R3, R4)
        step(1, 0, 3'd1, '0, 4'hF, 0, 0, '0, '0, '0, "R1");
        step(0, 0, '0, '0, '0, 1, 1, 3'd2, 32'hCAFE_0002, 4'hF, "R1");
        step(0, 0, '0, '0, '0, 1, 0, 3'd2, '0, 4'hF, "R3");
        idle("R4");
        // collision: engine busy three cycles, peripheral write held (R2, R8)
        step(1, 1, 3'd3, 32'hAAAA_0003, 4'hF, 1, 1, 3'd4, 32'hBEEF_0004, 4'hF, "R2");
        step(1, 0, 3'd4, '0, 4'hF, 1, 1, 3'd4, 32'hBEEF_0004, 4'hF, "R2");
        step(1, 0, 3'd3, '0, 4'hF, 1, 1, 3'd4, 32'hBEEF_0004, 4'hF, "R2");
        step(0, 0, '0, '0, '0, 1, 1, 3'd4, 32'hBEEF_0004, 4'hF, "R2");
        step(0, 0, '0, '0, '0, 1, 0, 3'd4, '0, 4'hF, "R8");
        idle("R8");
        // stalled read also completes once engine idles (R8)
        step(1, 1, 3'd5, 32'h5555_5555, 4'hF, 1, 0, 3'd5, '0, 4'hF, "R8");
        step(0, 0, '0, '0, '0, 1, 0, 3'd5, '0, 4'hF, "R8");
        idle("R8");
        // byte enables (R5)
        step(0, 0, '0, '0, '0, 1, 1, 3'd1, 32'h1122_3344, 4'b0101, "R5");
        step(1, 0, 3'd1, '0, 4'hF, 0, 0, '0, '0, '0, "R5");
        step(1, 1, 3'd1, 32'hFFFF_FFFF, 4'b0000, 0, 0, '0, '0, '0, "R5");
        step(0, 0, '0, '0, '0, 1, 0, 3'd1, '0, 4'hF, "R5");
        step(1, 1, 3'd6, 32'hDDCC_BBAA, 4'b1010, 0, 0, '0, '0, '0, "R5");
        step(1, 0, 3'd6, '0, 4'hF, 0, 0, '0, '0, '0, "R5");
        idle("R5");
        // random mixed traffic with held stalled peripheral requests (R6)
        begin
            logic pr = 0, pw = 0;
            logic [AW-1:0] pa = '0;
            logic [DW-1:0] pd = '0;
            logic [BW-1:0] pbe = '0;
            for (int n = 0; n < 3000; n++) begin
                logic er;
                if (!(pb_req && pb_wait)) begin
                    pr  = ($urandom % 10) < 6;
                    pw  = $urandom % 2;
                    pa  = AW'($urandom);
                    pd  = $urandom;
                    pbe = BW'($urandom);
                end
                er = ($urandom % 2) == 1;
                step(er, 1'($urandom), AW'($urandom), $urandom, BW'($urandom),
                     pr, pw, pa, pd, pbe, "R6");
            end
        end
        idle("R6");
        idle("R6");
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog run did not complete");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule